// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Wrap Order

This block produces the word address for a synchronous burst memory. When the access controller signals that an address strobe has been accepted, the block registers the full external address. The upper bits then stay fixed for the rest of the burst. The low two bits step through a four-beat sequence that wraps around. An active-low advance input moves the burst forward by one beat per clock. While that input is high the current address is held, which suspends the burst.

A static mode input picks the beat order. With mode low, the order is linear: the start offset plus the beat count, modulo four. With mode high, the order is interleaved: the start offset XOR the beat count. A burst may start at any of the four offsets. The controller resolves strobe priority and chip-enable qualification before the load pulse reaches this block. The memory array is outside it.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no other activity, addr_o and beat_o are all zeros.
- R2: A rising clock edge with load_i high registers the whole of addr_i and clears the beat count. After that edge, addr_o equals the loaded address and beat_o equals 0.
- R3: On an edge where load_i is high, adv_ni has no effect: beat_o is 0 after that edge whatever adv_ni was.
- R4: On an edge with load_i low and adv_ni low, beat_o increases by one, modulo 4.
- R5: On an edge with load_i low and adv_ni high, beat_o and addr_o keep their values.
- R6: With mode_i = 0 (linear), addr_o[1:0] equals (start offset + beat_o) mod 4. Starts 0, 1, 2 and 3 give 0-1-2-3, 1-2-3-0, 2-3-0-1 and 3-0-1-2.
- R7: With mode_i = 1 (interleaved), addr_o[1:0] equals start offset XOR beat_o. Starts 0, 1, 2 and 3 give 0-1-2-3, 1-0-3-2, 2-3-0-1 and 3-2-1-0.
- R8: Advancing after the fourth beat returns addr_o[1:0] to the start offset and beat_o to 0. The burst does not stop.
- R9: addr_o[ADDR_W-1:2] changes only on an edge with load_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External word address |
| load_i | input | 1 | Accepted address strobe from the access controller |
| adv_ni | input | 1 | Advance the burst by one beat, active low |
| mode_i | input | 1 | Beat order: 0 linear, 1 interleaved; held static |
| addr_o | output | ADDR_W | Current array word address |
| beat_o | output | 2 | Beats advanced since the last load |

## Verification
The bench builds the block with ADDR_W = 8. Six upper bits are enough to load distinct, non-zero upper patterns and show that they survive a whole burst, a suspension and a wrap unchanged. The two-bit low field is the same as at any width, so every start offset in both orders can be walked through all four beats and on into the wrap. Loads with the advance input held low are mixed into running bursts, so the rule that a load takes precedence over advancing is exercised in the middle of a sequence.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
#(
  parameter int unsigned CNT_W = BEAT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_ni,
  output logic [CNT_W-1:0] beat_o
);
  logic [CNT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_q <= '0;
    else if (load_i)  beat_q <= '0;      // load wins, advance ignored
    else if (!adv_ni) beat_q <= beat_q + 1'b1;
  end

  assign beat_o = beat_q;

  // R2 / R3
  a_r3_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> beat_o == '0);
  // R4
  a_r4_advance_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni) |=> beat_o == CNT_W'($past(beat_o) + 1'b1));
  // R5
  a_r5_suspend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && adv_ni) |=> $stable(beat_o));
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import bas_pkg::*;
#(
  parameter int unsigned CNT_W = BEAT_W
) (
  input  logic       [CNT_W-1:0] start_i,
  input  logic       [CNT_W-1:0] beat_i,
  input  order_e                 order_i,
  output logic       [CNT_W-1:0] low_o
);
  logic [CNT_W-1:0] lin_w, ilv_w;

  assign lin_w = start_i + beat_i;   // wraps mod 2**CNT_W
  assign ilv_w = start_i ^ beat_i;

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: low_o = ilv_w;
      default:        low_o = lin_w;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_i,
  input  logic              adv_ni,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [1:0]        beat_o
);
  localparam int unsigned UP_W = ADDR_W - BEAT_W;

  logic [UP_W-1:0]   upper_q;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_w;
  logic [BEAT_W-1:0] low_w;
  order_e            order_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_q <= '0;
      start_q <= '0;
    end else if (load_i) begin
      upper_q <= addr_i[ADDR_W-1:BEAT_W];
      start_q <= addr_i[BEAT_W-1:0];
    end
  end

  bas_beat_ctr #(.CNT_W(BEAT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .adv_ni (adv_ni),
    .beat_o (beat_w)
  );

  assign order_w = mode_i ? ORD_INTERLEAVE : ORD_LINEAR;

  bas_order_map #(.CNT_W(BEAT_W)) u_map (
    .start_i (start_q),
    .beat_i  (beat_w),
    .order_i (order_w),
    .low_o   (low_w)
  );

  assign addr_o = {upper_q, low_w};
  assign beat_o = beat_w;

  // R2
  a_r2_load_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(addr_i));
  // R9
  a_r9_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
  // R8
  a_r8_wrap_to_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_ni && beat_o == 2'd3) |=> (beat_o == 2'd0 && addr_o[1:0] == start_q));
endmodule

// File: tb/tb_burst_addr_seq.sv
`timescale 1ns/1ps
module tb_burst_addr_seq;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          load = 1'b0;
  logic          adv_n = 1'b1;
  logic          mode = 1'b0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr_in), .load_i (load),
    .adv_ni (adv_n), .mode_i (mode), .addr_o (addr_out), .beat_o (beat)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_low(input logic m, input logic [1:0] s, input logic [1:0] b);
    return m ? (s ^ b) : 2'(s + b);
  endfunction

  // Drive at negedge, let one rising edge pass, sample at the next negedge.
  task automatic step(input logic ld, input logic [AW-1:0] a, input logic advn);
    @(negedge clk);
    load = ld; addr_in = a; adv_n = advn;
    @(posedge clk);
    @(negedge clk);
    load = 1'b0; adv_n = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 addr in reset", int'(addr_out), 0);
    check("R1 beat in reset", int'(beat), 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 addr after release", int'(addr_out), 0);
    check("R1 beat after release", int'(beat), 0);
  endtask

  task automatic t_load;
    mode = 1'b0;
    step(1'b1, 8'hA6, 1'b1);
    check("R2 load addr", int'(addr_out), 'hA6);
    check("R2 load beat", int'(beat), 0);
  endtask

  task automatic t_adv_on_load;
    step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b0);   // beat now 2
    step(1'b1, 8'h5D, 1'b0);
    check("R3 beat on load with adv low", int'(beat), 0);
    check("R3 addr on load with adv low", int'(addr_out), 'h5D);
  endtask

  task automatic t_walk(input logic m, input string req);
    mode = m;
    for (int s = 0; s < 4; s++) begin
      logic [AW-1:0] base = AW'((s + 1) * 8'h24) & 8'hFC;
      step(1'b1, base | AW'(s), 1'b1);
      for (int b = 0; b < 4; b++) begin
        check(req, int'(addr_out), int'(base | AW'(exp_low(m, 2'(s), 2'(b)))));
        check("R4 beat count", int'(beat), b);
        step(1'b0, '0, 1'b0);
      end
      check("R8 wrap low", int'(addr_out[1:0]), s);
      check("R8 wrap beat", int'(beat), 0);
      check("R9 upper after wrap", int'(addr_out[AW-1:2]), int'(base[AW-1:2]));
    end
  endtask

  task automatic t_suspend;
    mode = 1'b1;
    step(1'b1, 8'hC3, 1'b1);
    step(1'b0, 8'h00, 1'b0);
    check("R7 ilv beat1", int'(addr_out), 'hC2);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 8'hFF, 1'b1);
      check("R5 hold addr", int'(addr_out), 'hC2);
      check("R5 hold beat", int'(beat), 1);
    end
    step(1'b0, 8'h3C, 1'b0);
    check("R9 upper ignores addr_i", int'(addr_out), 'hC1);
  endtask

  task automatic t_reload_mid;
    mode = 1'b0;
    step(1'b1, 8'h11, 1'b1);
    step(1'b0, '0, 1'b0);
    step(1'b1, 8'h92, 1'b0);
    check("R2 reload mid burst", int'(addr_out), 'h92);
    step(1'b0, '0, 1'b0);
    check("R6 lin after reload", int'(addr_out), 'h93);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_load();
        t_adv_on_load();
        t_walk(1'b0, "R6 linear order");
        t_walk(1'b1, "R7 interleaved order");
        t_suspend();
        t_reload_mid();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule